// File: doc/BRIEF.md
# Double-Buffered Byte-to-Serial Loader

This block takes bytes from a host over an asynchronous, strobe-based write port and sends them out one bit per clock on a single serial line. The host qualifies each write with two chip selects and a write strobe. The loader brings the strobe into its own clock domain and parks the byte in a holding register. From there the byte passes to a shift register, which sends it least significant bit first. Because there are two storage levels, one byte can wait while the previous one is still shifting, and back-to-back bytes come out as a continuous stream.

A ready output tells the host whether another byte may be written. It goes low shortly after a write ends and comes back high once the holding register has handed its byte to the shifter. Ready therefore stays low for two cycles when the loader was empty, and for longer when the shifter is still busy with an earlier byte. The host may begin the next write as soon as ready goes low. It must keep that write asserted until it has seen ready high for one full clock. The host can also read the ready flag back over the status bus with a read strobe.

Top module: `byte_serial_loader`

## Requirements
- R1: A write is qualified only while `host_wr_n`=0, `host_sel_lo_n`=0, `host_rd_n`=1 and `host_sel_hi`=1. A strobe pulse that fails any one of these terms leaves `ser_out` idle high and `host_ready` high.
- R2: The byte taken is the value on `host_data_in` at the last rising clock edge at which the write was qualified. Changing the bus after the strobe ends has no effect on that byte.
- R3: Take the first rising edge at which a write is no longer qualified. `host_ready` is low in the cycle that follows the second rising edge after it.
- R4: When both storage levels are empty, `host_ready` stays low for exactly 2 cycles after a write. It returns high in the same cycle that bit 0 of that byte first appears on `ser_out`.
- R5: `ser_out` carries a byte's bits 0 to 7, least significant bit first, one bit per cycle. It is high whenever no byte is shifting.
- R6: Suppose a byte is held while the shifter is busy. Its bit 0 then appears in the cycle right after bit 7 of the previous byte, with no idle gap, and `host_ready` returns high in that same cycle.
- R7: `host_ready` is never low for more than DATA_W+1 (9) consecutive cycles.
- R8: While `host_rd_n`=0, `host_sel_lo_n`=0, `host_sel_hi`=1 and `host_wr_n`=1, `host_stat_oe` is 1 and `host_stat_out` shows `host_ready` in its top bit (bit 7), with all other bits 0. Otherwise `host_stat_oe` is 0 and `host_stat_out` is all zero.
- R9: During and after reset, `host_ready`=1, `ser_out`=1 and `host_stat_oe`=0.
- R10: A write may end while the holding register is full, in a cycle in which the held byte is not moving into the shifter. That write is discarded, and none of its bits ever appear on `ser_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; one serial bit per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_sel_lo_n | input | 1 | Chip select, active low |
| host_sel_hi | input | 1 | Chip select, active high |
| host_data_in | input | DATA_W | Host write data |
| host_stat_out | output | DATA_W | Status read data, ready flag in top bit |
| host_stat_oe | output | 1 | High while a status read is selected |
| host_ready | output | 1 | High when a new byte may be written |
| ser_out | output | 1 | Serial bitstream, idle high |

## Verification
The bench places bit 0 of every byte at the cycle where ready rises, then decodes eight bits from there. A loader that adds a gap between back-to-back bytes, sends the bits in the wrong order, or releases ready one cycle early or late fails this decode. It also fails the exact 2-cycle busy check in the empty case. A directed sequence ends a third write while the holding register is still occupied and the shifter is mid-byte. A design that overwrote the holding register would then emit the wrong second byte or a third byte. The bench also drives a new byte onto the bus in the same cycle a strobe is released. This catches a loader that samples data at or after the synchronised strobe edge instead of while the write is still qualified.

// File: rtl/serial_loader_pkg.sv
// Package: shared type for the byte-to-serial loader.
// Holds the shifter state encoding that the shifter module uses.
package serial_loader_pkg;

    // Shifter activity: idle drives the line high, run emits bits
    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } shift_state_e;

endpackage

// File: rtl/loader_strobe_sync.sv
// Module: loader_strobe_sync
// Decodes the asynchronous host strobes. Passes the write qualification
// through a synchroniser chain and pulses wr_done for one cycle when the
// synchronised write ends. The data bus is staged on every edge at which
// the raw write qualification is high, so the byte survives the
// synchroniser latency even after the host drops it.
// Assumes: the host holds data stable while the write is qualified and
// does not start a new write until ready has gone low.
module loader_strobe_sync #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              sel_lo_n,
    input  logic              sel_hi,
    input  logic [DATA_W-1:0] data_in,
    output logic              wr_done,
    output logic [DATA_W-1:0] wr_byte,
    output logic              rd_sel
);

    localparam int unsigned LAST_STG = SYNC_STAGES - 1;

    logic                   raw_wr;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   hist_q;
    logic [DATA_W-1:0]      stage_q;

    // Raw write and read qualification from the pins
    always_comb begin
        raw_wr = !wr_n && !sel_lo_n && rd_n && sel_hi;
        rd_sel = !rd_n && !sel_lo_n && sel_hi && wr_n;
    end

    // First synchroniser stage samples the raw qualification
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q[0] <= 1'b0;
        end else begin
            sync_q[0] <= raw_wr;
        end
    end

    // Remaining synchroniser stages, one flop each
    generate
        for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sync_q[g] <= 1'b0;
                end else begin
                    sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // History flop for falling-edge detection of the synchronised write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= 1'b0;
        end else begin
            hist_q <= sync_q[LAST_STG];
        end
    end

    // Staging register follows the bus while the write is qualified
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else if (raw_wr) begin
            stage_q <= data_in;
        end
    end

    // End of write: synchronised qualification has just dropped
    always_comb begin
        wr_done = hist_q && !sync_q[LAST_STG];
        wr_byte = stage_q;
    end

    // R3: the end pulse lasts exactly one cycle
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !wr_done)
        else $error("write-end pulse longer than one cycle");

    // R2: staged byte only changes while the write is qualified
    p_stage_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_wr |=> $stable(stage_q))
        else $error("staged byte changed outside a write");

endmodule

// File: rtl/loader_hold_buf.sv
// Module: loader_hold_buf
// First storage level. Accepts a byte on wr_done when it is empty, or when
// its present byte moves to the shifter in the same cycle. Hands its byte
// to the shifter whenever the shifter can take one. It generates ready
// from its own occupancy and the pending write-end pulse.
// Assumes: wr_done is a single-cycle pulse in the clk domain.
module loader_hold_buf #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_done,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              can_take,
    output logic              load,
    output logic [DATA_W-1:0] hold_byte,
    output logic              ready
);

    localparam int unsigned RUN_MAX = DATA_W + 2;
    localparam int unsigned RUN_W   = $clog2(RUN_MAX + 1);

    logic              hold_full_q;
    logic [DATA_W-1:0] hold_q;
    logic              accept;
    logic [RUN_W-1:0]  busy_run_q;

    // Handoff and accept decisions for this cycle
    always_comb begin
        load      = hold_full_q && can_take;
        accept    = wr_done && (!hold_full_q || load);
        hold_byte = hold_q;
        ready     = !hold_full_q && !wr_done;
    end

    // Occupancy flag and byte storage of the holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_full_q <= 1'b0;
            hold_q      <= '0;
        end else if (accept) begin
            hold_full_q <= 1'b1;
            hold_q      <= wr_byte;
        end else if (load) begin
            hold_full_q <= 1'b0;
        end
    end

    // Checker counter: length of the current busy run, saturating
    always_ff @(posedge clk) begin
        if (!rst_n || ready) begin
            busy_run_q <= '0;
        end else if (busy_run_q < RUN_W'(RUN_MAX)) begin
            busy_run_q <= busy_run_q + RUN_W'(1);
        end
    end

    // R10: a write ending while full and not draining leaves the byte intact
    p_drop_keeps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && hold_full_q && !load) |=> (hold_full_q && $stable(hold_q)))
        else $error("held byte disturbed by a late write");

    // R4: ready only rises after a handoff to the shifter
    p_ready_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(load))
        else $error("ready rose without a handoff");

    // R7: busy never exceeds DATA_W+1 cycles
    p_busy_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run_q <= RUN_W'(DATA_W + 1))
        else $error("busy interval too long");

endmodule

// File: rtl/loader_shifter.sv
// Module: loader_shifter
// Second storage level. Loads a byte, then shifts it out LSB first, one bit
// per cycle, for DATA_W cycles. It can take the next byte when idle, or in
// the cycle that shows the final bit, so back-to-back bytes leave no gap.
// The line is held high while idle.
// Assumes: DATA_W is at least 2.
module loader_shifter
    import serial_loader_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_byte,
    output logic              can_take,
    output logic              ser_out
);

    localparam int unsigned CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    shift_state_e      state_q;
    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;

    // Load, shift and bit-count sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SH_IDLE;
            sh_q    <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            state_q <= SH_RUN;
            sh_q    <= load_byte;
            cnt_q   <= '0;
        end else if (state_q == SH_RUN) begin
            if (cnt_q == LAST) begin
                state_q <= SH_IDLE;
            end else begin
                sh_q  <= sh_q >> 1;
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    // Free-slot flag and serial line drive
    always_comb begin
        can_take = (state_q == SH_IDLE) || (cnt_q == LAST);
        ser_out  = (state_q == SH_RUN) ? sh_q[0] : 1'b1;
    end

    // R5: while running, the bit count advances by one each cycle
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SH_RUN && cnt_q != LAST && !load)
            |=> (state_q == SH_RUN && cnt_q == $past(cnt_q) + CNT_W'(1)))
        else $error("bit count skipped or stalled");

    // R6: a load only lands in a free slot
    p_load_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (state_q == SH_IDLE || cnt_q == LAST))
        else $error("shifter overwritten mid-byte");

endmodule

// File: rtl/byte_serial_loader.sv
// Module: byte_serial_loader (top)
// Connects the strobe synchroniser, the holding register and the shifter,
// and drives the status read bus with the ready flag in its top bit.
// Assumes: the host follows the ready handshake described in the brief.
module byte_serial_loader #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_n,
    input  logic              host_rd_n,
    input  logic              host_sel_lo_n,
    input  logic              host_sel_hi,
    input  logic [DATA_W-1:0] host_data_in,
    output logic [DATA_W-1:0] host_stat_out,
    output logic              host_stat_oe,
    output logic              host_ready,
    output logic              ser_out
);

    logic              wr_done;
    logic [DATA_W-1:0] wr_byte;
    logic              rd_sel;
    logic              can_take;
    logic              load;
    logic [DATA_W-1:0] hold_byte;
    logic              ready;

    loader_strobe_sync #(
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_n     (host_wr_n),
        .rd_n     (host_rd_n),
        .sel_lo_n (host_sel_lo_n),
        .sel_hi   (host_sel_hi),
        .data_in  (host_data_in),
        .wr_done  (wr_done),
        .wr_byte  (wr_byte),
        .rd_sel   (rd_sel)
    );

    loader_hold_buf #(
        .DATA_W (DATA_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_done   (wr_done),
        .wr_byte   (wr_byte),
        .can_take  (can_take),
        .load      (load),
        .hold_byte (hold_byte),
        .ready     (ready)
    );

    loader_shifter #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_byte (hold_byte),
        .can_take  (can_take),
        .ser_out   (ser_out)
    );

    // Status read mux and ready output
    always_comb begin
        host_ready    = ready;
        host_stat_oe  = rd_sel;
        host_stat_out = rd_sel ? {ready, {(DATA_W-1){1'b0}}} : '0;
    end

endmodule

// File: tb/test_byte_serial_loader.sv
module test_byte_serial_loader;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int LOG_N      = 4096;
    localparam int N_RAND     = 24;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         host_wr_n, host_rd_n, host_sel_lo_n, host_sel_hi;
    logic [W-1:0] host_data_in;
    logic [W-1:0] host_stat_out;
    logic         host_stat_oe, host_ready, ser_out;

    int total = 0;
    int bad   = 0;
    int cyc   = -1;
    logic ser_log [LOG_N];
    logic rdy_log [LOG_N];

    byte_serial_loader i_byte_serial_loader (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_wr_n     (host_wr_n),
        .host_rd_n     (host_rd_n),
        .host_sel_lo_n (host_sel_lo_n),
        .host_sel_hi   (host_sel_hi),
        .host_data_in  (host_data_in),
        .host_stat_out (host_stat_out),
        .host_stat_oe  (host_stat_oe),
        .host_ready    (host_ready),
        .ser_out       (ser_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Cycle log sampled a quarter period after each rising edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        cyc = cyc + 1;
        if (cyc >= 0 && cyc < LOG_N) begin
            ser_log[cyc] = ser_out;
            rdy_log[cyc] = host_ready;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // Rebuild a byte from the serial log, LSB first from cycle s
    function automatic logic [W-1:0] byte_at(input int s);
        logic [W-1:0] b;
        for (int i = 0; i < W; i++) begin
            b[i] = (s + i >= 0 && s + i < LOG_N) ? ser_log[s + i] : 1'bx;
        end
        return b;
    endfunction

    function automatic logic rdy_at(input int c);
        return (c >= 0 && c < LOG_N) ? rdy_log[c] : 1'bx;
    endfunction

    function automatic logic ser_at(input int c);
        return (c >= 0 && c < LOG_N) ? ser_log[c] : 1'bx;
    endfunction

    task automatic bus_idle();
        host_wr_n = 1'b1; host_rd_n = 1'b1; host_sel_lo_n = 1'b1; host_sel_hi = 1'b0;
    endtask

    // Host write from a negedge; obey=1 waits for ready high, then holds extra cycles
    task automatic host_write(input logic [W-1:0] d, input int extra, input bit obey,
                              output int rel, output int rise);
        host_data_in = d; host_wr_n = 1'b0; host_sel_lo_n = 1'b0;
        host_sel_hi = 1'b1; host_rd_n = 1'b1;
        rise = -1;
        if (obey) begin
            while (host_ready !== 1'b1) @(negedge clk);
            rise = cyc;
            repeat (extra) @(negedge clk);
        end
        @(negedge clk);
        bus_idle();
        host_data_in = W'($urandom);
        rel = cyc;
    endtask

    task automatic wait_ready(input logic lvl, output int c);
        while (host_ready !== lvl) @(negedge clk);
        c = cyc;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog act=%0h exp=%0h", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int rA, rB, rC, rD, rs, riseB, c, s, run, maxrun;
        logic [W-1:0] A, B, C, D;
        logic [W-1:0] rbytes [N_RAND];
        int           rstart [N_RAND];
        int           rrel;
        int           rrise;
        bit           gap;

        void'($urandom(32'h5EED_1234));
        rst_n = 1'b0;
        bus_idle();
        host_data_in = '0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check(host_ready === 1'b1, "R9 ready in reset", host_ready, 1);
        check(ser_out === 1'b1, "R9 serial idle in reset", ser_out, 1);
        check(host_stat_oe === 1'b0, "R9 stat oe in reset", host_stat_oe, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(host_ready === 1'b1 && ser_out === 1'b1, "R9 after reset", {host_ready, ser_out}, 3);

        // R8: status read while idle, then with a select missing
        host_rd_n = 1'b0; host_sel_lo_n = 1'b0; host_sel_hi = 1'b1;
        #1;
        check(host_stat_oe === 1'b1 && host_stat_out === 8'h80, "R8 idle read", host_stat_out, 8'h80);
        host_sel_hi = 1'b0;
        #1;
        check(host_stat_oe === 1'b0 && host_stat_out === 8'h00, "R8 deselected read", host_stat_out, 0);
        bus_idle();
        @(negedge clk);

        // R1: strobes with one qualification term wrong are ignored
        for (int v = 0; v < 3; v++) begin
            host_data_in = 8'h00; host_wr_n = 1'b0; host_sel_lo_n = 1'b0;
            host_rd_n = 1'b1; host_sel_hi = 1'b1;
            if (v == 0) host_sel_lo_n = 1'b1;
            if (v == 1) host_rd_n = 1'b0;
            if (v == 2) host_sel_hi = 1'b0;
            s = cyc;
            repeat (3) @(negedge clk);
            bus_idle();
            wait_until(s + 16);
            run = 1;
            for (int k = s; k < s + 16; k++) begin
                if (rdy_at(k) !== 1'b1 || ser_at(k) !== 1'b1) run = 0;
            end
            check(run == 1, "R1 unqualified strobe ignored", v, 1);
        end

        // Directed: A into empty loader, B held behind A, C ends while full
        A = 8'h3C; B = 8'hC1; C = 8'h5A;
        host_write(A, 0, 1'b1, rA, rs);
        wait_ready(1'b0, c);
        check(c == rA + 2, "R3 ready falls after end", c - rA, 2);
        host_write(B, 0, 1'b1, rB, riseB);
        check(riseB == rA + 4, "R4 busy exactly 2 cycles", riseB - rA, 4);
        wait_ready(1'b0, c);
        host_write(C, 0, 1'b0, rC, rs);
        wait_until(rA + 34);
        check(rdy_at(rA+1) === 1'b1 && rdy_at(rA+2) === 1'b0 && rdy_at(rA+3) === 1'b0
              && rdy_at(rA+4) === 1'b1, "R4 ready pattern",
              {rdy_at(rA+1), rdy_at(rA+2), rdy_at(rA+3), rdy_at(rA+4)}, 4'b1001);
        check(ser_at(rA+3) === 1'b1, "R5 idle before first bit", ser_at(rA+3), 1);
        check(byte_at(rA+4) === A, "R2 R5 first byte", byte_at(rA+4), A);
        check(byte_at(rA+12) === B, "R6 second byte without gap", byte_at(rA+12), B);
        check(rdy_at(rA+11) === 1'b0 && rdy_at(rA+12) === 1'b1, "R6 ready with bit 0",
              {rdy_at(rA+11), rdy_at(rA+12)}, 2'b01);
        run = 1;
        for (int k = rA + 20; k < rA + 34; k++) begin
            if (ser_at(k) !== 1'b1 || rdy_at(k) !== 1'b1) run = 0;
        end
        check(run == 1, "R10 late write discarded", run, 1);

        // R8: status read while busy shows ready low
        D = 8'h96;
        host_write(D, 0, 1'b1, rD, rs);
        @(negedge clk);
        @(negedge clk);
        host_rd_n = 1'b0; host_sel_lo_n = 1'b0; host_sel_hi = 1'b1;
        #1;
        check(host_stat_oe === 1'b1 && host_stat_out === 8'h00, "R8 busy read", host_stat_out, 0);
        bus_idle();
        wait_until(rD + 16);
        check(byte_at(rD + 4) === D, "R5 byte after read", byte_at(rD + 4), D);

        // Random back-to-back and gapped writes
        for (int k = 0; k < N_RAND; k++) begin
            rbytes[k] = W'($urandom);
            host_write(rbytes[k], int'($urandom_range(0, 2)), 1'b1, rrel, rrise);
            if (k > 0 && !gap) rstart[k-1] = rrise;
            wait_ready(1'b0, c);
            check(c == rrel + 2, "R3 random ready fall", c - rrel, 2);
            gap = (k == N_RAND - 1) || ($urandom_range(0, 3) == 0);
            if (gap) begin
                wait_ready(1'b1, c);
                rstart[k] = c;
                repeat ($urandom_range(0, 12)) @(negedge clk);
            end
        end
        wait_until(rstart[N_RAND-1] + 12);
        for (int k = 0; k < N_RAND; k++) begin
            check(byte_at(rstart[k]) === rbytes[k], "R5 R6 random byte", byte_at(rstart[k]), rbytes[k]);
        end

        // R7: longest busy run over the whole log
        run = 0; maxrun = 0;
        for (int k = 0; k <= cyc && k < LOG_N; k++) begin
            if (rdy_log[k] === 1'b0) run++; else run = 0;
            if (run > maxrun) maxrun = run;
        end
        check(maxrun <= W + 1, "R7 busy bound", maxrun, W + 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule